// File: doc/BRIEF.md
# Decode-Stage Stall Generator

This block decides when the front of a five-stage in-order pipeline has to wait because a value cannot yet be forwarded. It compares the source register numbers of the instruction sitting in decode against two producers: the destination of the instruction in the ID/EX register and the destination of the instruction in the EX/MEM register. When a dependency cannot be forwarded in time, it freezes the program counter and the IF/ID register and turns the next ID/EX entry into a bubble.

There are two rules. An ordinary consumer only waits when a load in ID/EX produces one of its sources, because the loaded word does not exist until the memory stage. A branch is compared in decode, so it needs its operands a stage earlier. It therefore also waits on an ALU result still in ID/EX and on a load result still in EX/MEM. A branch that follows a load waits for two cycles in a row. The bubble clears every write and memory enable, so it changes nothing in the architectural state. All outputs are combinational from the current pipeline-register contents. The stall drops as soon as the pipeline state that caused it has moved on.

Top module: `hazard_stall_unit`

## Requirements
- R1: When the ID/EX mem-read flag is 1 and the ID/EX destination is nonzero and equals either decode source, `stall_o` is 1, whether or not the decode instruction is a branch.
- R2: When the decode branch flag is 1 and the ID/EX reg-write flag is 1 with a nonzero ID/EX destination equal to either decode source, `stall_o` is 1. A non-branch consumer of the same ALU result does not stall.
- R3: When the decode branch flag is 1 and the EX/MEM mem-read flag is 1 with a nonzero EX/MEM destination equal to either decode source, `stall_o` is 1. A non-branch consumer of that load does not stall.
- R4: A branch that directly follows a load writing one of its sources stalls for exactly two consecutive cycles as the load moves from ID/EX to EX/MEM. It proceeds on the third cycle.
- R5: A match on register number 0 never causes a stall, whatever the producer flags are.
- R6: While `stall_o` is 1, `pc_write_en` and `ifid_write_en` are 0 and `idex_bubble` is 1. While `stall_o` is 0, the two write enables are 1 and `idex_bubble` is 0.
- R7: The following cases do not stall: an ID/EX producer with both reg-write and mem-read at 0, an EX/MEM producer whose mem-read is 0, and any case where no destination matches a source.
- R8: The outputs are combinational. When the inputs change so that no hazard remains, `stall_o` falls with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_AW | First source register of the decode instruction |
| id_src_b | input | REG_AW | Second source register of the decode instruction |
| id_is_branch | input | 1 | Decode instruction is a branch compared in decode |
| ex_dst | input | REG_AW | Destination register held in ID/EX |
| ex_mem_read | input | 1 | ID/EX instruction is a load |
| ex_reg_write | input | 1 | ID/EX instruction writes a register |
| mem_dst | input | REG_AW | Destination register held in EX/MEM |
| mem_mem_read | input | 1 | EX/MEM instruction is a load |
| stall_o | output | 1 | Hazard present, front of pipeline waits |
| pc_write_en | output | 1 | Program counter may update |
| ifid_write_en | output | 1 | IF/ID register may update |
| idex_bubble | output | 1 | Load a bubble into ID/EX at the next edge |

## Verification
The hardest case to reach is the two-cycle branch-after-load wait. No single input vector shows it, because it depends on how the pipeline registers change between cycles. The bench therefore steps a small model of the pipeline: each stalled cycle moves the load from ID/EX to EX/MEM and puts a bubble in ID/EX, while the branch stays in decode. The bench counts how many cycles are stalled. A second directed case removes the hazard between clock edges and confirms that the stall falls at once. The vector table covers each rule from both sides, including matches on either source and matches on register 0.

// File: rtl/hazard_stall_unit.sv
module hazard_stall_unit #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              id_is_branch,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_mem_read,
  input  logic              ex_reg_write,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_mem_read,
  output logic              stall_o,
  output logic              pc_write_en,
  output logic              ifid_write_en,
  output logic              idex_bubble
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic ex_hit, mem_hit;
  logic load_use, br_on_alu, br_on_load;

  assign ex_hit  = (ex_dst  != ZERO_REG) && ((ex_dst  == id_src_a) || (ex_dst  == id_src_b));
  assign mem_hit = (mem_dst != ZERO_REG) && ((mem_dst == id_src_a) || (mem_dst == id_src_b));

  assign load_use   = ex_mem_read & ex_hit;
  assign br_on_alu  = id_is_branch & ex_reg_write & ex_hit;
  assign br_on_load = id_is_branch & mem_mem_read & mem_hit;

  assign stall_o       = load_use | br_on_alu | br_on_load;
  assign pc_write_en   = ~stall_o;
  assign ifid_write_en = ~stall_o;
  assign idex_bubble   = stall_o;
endmodule

// File: rtl/hazard_stall_unit_chk.sv
module hazard_stall_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] id_src_a,
  input logic [REG_AW-1:0] id_src_b,
  input logic              id_is_branch,
  input logic [REG_AW-1:0] ex_dst,
  input logic              ex_mem_read,
  input logic              ex_reg_write,
  input logic [REG_AW-1:0] mem_dst,
  input logic              mem_mem_read,
  input logic              stall_o,
  input logic              pc_write_en,
  input logic              ifid_write_en,
  input logic              idex_bubble
);
  always_comb begin
    if (stall_o)
      assert_stall_ctrl_R6: assert (!pc_write_en && !ifid_write_en && idex_bubble);
    if (!stall_o)
      assert_run_ctrl_R6: assert (pc_write_en && ifid_write_en && !idex_bubble);
    if (ex_mem_read && ex_dst != '0 && (ex_dst == id_src_a || ex_dst == id_src_b))
      assert_load_use_R1: assert (stall_o);
    if (id_is_branch && ex_reg_write && ex_dst != '0 && (ex_dst == id_src_a || ex_dst == id_src_b))
      assert_branch_alu_R2: assert (stall_o);
    if (ex_dst == '0 && mem_dst == '0)
      assert_zero_reg_R5: assert (!stall_o);
    if (!ex_mem_read && !ex_reg_write && !mem_mem_read)
      assert_quiet_R7: assert (!stall_o);
    if (!id_is_branch && !ex_mem_read)
      assert_nonbranch_R3: assert (!stall_o);
  end
endmodule

bind hazard_stall_unit hazard_stall_unit_chk #(.REG_AW(REG_AW)) chk_i (
  .id_src_a(id_src_a), .id_src_b(id_src_b), .id_is_branch(id_is_branch),
  .ex_dst(ex_dst), .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write),
  .mem_dst(mem_dst), .mem_mem_read(mem_mem_read),
  .stall_o(stall_o), .pc_write_en(pc_write_en),
  .ifid_write_en(ifid_write_en), .idex_bubble(idex_bubble)
);

// File: tb/hazard_stall_unit_tb.sv
module hazard_stall_unit_tb_top;
  localparam int AW = 5;

  typedef struct packed {
    logic [AW-1:0] sa;
    logic [AW-1:0] sb;
    logic          br;
    logic [AW-1:0] exd;
    logic          exmr;
    logic          exrw;
    logic [AW-1:0] memd;
    logic          memmr;
    logic          exp;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{5'd3,  5'd4, 1'b0, 5'd3, 1'b1, 1'b1, 5'd0,  1'b0, 1'b1, 4'd1}, // R1 match on first source
    '{5'd3,  5'd4, 1'b0, 5'd4, 1'b1, 1'b1, 5'd0,  1'b0, 1'b1, 4'd1}, // R1 match on second source
    '{5'd3,  5'd4, 1'b0, 5'd5, 1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 4'd7}, // R7 load, no match
    '{5'd3,  5'd4, 1'b1, 5'd3, 1'b0, 1'b1, 5'd0,  1'b0, 1'b1, 4'd2}, // R2 branch on ALU result
    '{5'd3,  5'd4, 1'b0, 5'd3, 1'b0, 1'b1, 5'd0,  1'b0, 1'b0, 4'd2}, // R2 non-branch forwards
    '{5'd3,  5'd4, 1'b1, 5'd9, 1'b0, 1'b1, 5'd4,  1'b1, 1'b1, 4'd3}, // R3 branch on EX/MEM load
    '{5'd3,  5'd4, 1'b0, 5'd9, 1'b0, 1'b1, 5'd4,  1'b1, 1'b0, 4'd3}, // R3 non-branch forwards
    '{5'd3,  5'd4, 1'b1, 5'd9, 1'b0, 1'b1, 5'd3,  1'b0, 1'b0, 4'd7}, // R7 EX/MEM ALU result
    '{5'd0,  5'd4, 1'b0, 5'd0, 1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 4'd5}, // R5 load to x0
    '{5'd0,  5'd0, 1'b1, 5'd0, 1'b0, 1'b1, 5'd0,  1'b1, 1'b0, 4'd5}, // R5 branch on x0
    '{5'd3,  5'd4, 1'b1, 5'd3, 1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 4'd7}, // R7 producer writes nothing
    '{5'd7,  5'd7, 1'b1, 5'd7, 1'b1, 1'b1, 5'd0,  1'b0, 1'b1, 4'd1}, // R1 both sources equal
    '{5'd31, 5'd1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd31, 1'b1, 1'b1, 4'd3}  // R3 top register number
  };

  logic [AW-1:0] id_src_a, id_src_b, ex_dst, mem_dst;
  logic id_is_branch, ex_mem_read, ex_reg_write, mem_mem_read;
  logic stall_o, pc_write_en, ifid_write_en, idex_bubble;
  logic clk = 1'b0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hazard_stall_unit #(.REG_AW(AW)) dut_i (
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_is_branch(id_is_branch),
    .ex_dst(ex_dst), .ex_mem_read(ex_mem_read), .ex_reg_write(ex_reg_write),
    .mem_dst(mem_dst), .mem_mem_read(mem_mem_read),
    .stall_o(stall_o), .pc_write_en(pc_write_en),
    .ifid_write_en(ifid_write_en), .idex_bubble(idex_bubble)
  );

  task automatic drive(input logic [AW-1:0] sa, input logic [AW-1:0] sb, input logic br,
                       input logic [AW-1:0] exd, input logic exmr, input logic exrw,
                       input logic [AW-1:0] memd, input logic memmr);
    id_src_a = sa; id_src_b = sb; id_is_branch = br;
    ex_dst = exd; ex_mem_read = exmr; ex_reg_write = exrw;
    mem_dst = memd; mem_mem_read = memmr;
  endtask

  task automatic check(input string req, input logic exp);
    logic [3:0] got, want;
    got  = {stall_o, pc_write_en, ifid_write_en, idex_bubble};
    want = {exp, !exp, !exp, exp};
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL %s stall/pcwe/ifidwe/bubble actual=%b expected=%b", req, got, want);
    end
  endtask

  initial begin
    drive('0, '0, 1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    @(negedge clk);
    check("R6 idle state", 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].sa, VECS[i].sb, VECS[i].br, VECS[i].exd,
            VECS[i].exmr, VECS[i].exrw, VECS[i].memd, VECS[i].memmr);
      #1;
      check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].exp);
    end

    // R4: branch on x6 directly behind a load of x6; model the pipe registers
    begin
      logic [AW-1:0] p_exd, p_memd;
      logic p_exmr, p_exrw, p_memmr;
      int stalled = 0;
      p_exd = 5'd6; p_exmr = 1'b1; p_exrw = 1'b1;
      p_memd = 5'd0; p_memmr = 1'b0;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        drive(5'd6, 5'd2, 1'b1, p_exd, p_exmr, p_exrw, p_memd, p_memmr);
        #1;
        if (stall_o) stalled++;
        if (c == 0) check("R4 first wait", 1'b1);
        if (c == 1) check("R4 second wait", 1'b1);
        if (c == 2) check("R4 proceeds", 1'b0);
        if (!stall_o) break;
        p_memd = p_exd; p_memmr = p_exmr;
        p_exd = '0; p_exmr = 1'b0; p_exrw = 1'b0;
      end
      checks++;
      if (stalled != 2) begin
        failures++;
        $display("FAIL R4 stalled cycles actual=%0d expected=2", stalled);
      end
    end

    // R8: hazard disappears between edges
    @(posedge clk);
    #1;
    drive(5'd8, 5'd1, 1'b0, 5'd8, 1'b1, 1'b1, 5'd0, 1'b0);
    #0.5;
    check("R8 hazard raised", 1'b1);
    ex_dst = 5'd9;
    #0.5;
    check("R8 released without edge", 1'b0);

    // R5 with every producer flag raised
    @(negedge clk);
    drive(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1);
    #1;
    check("R5 all flags on x0", 1'b0);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule